// File: doc/BRIEF.md
# Programmable Crosspoint Output Cell

This block is one output cell of a configurable signal-routing fabric, together with the small input-side routing pool that feeds it. Four groups of input pins each supply one data candidate to the cell. Any pin in the combined pool can drive four per-cell control lines: output enable, storage clock and two run-time select lines. Each control line has its own configurable polarity. The two selects pick one of the four data candidates on every cycle, so an output can be switched between up to four sources while running.

The chosen data reaches the pad through one of three paths: directly, through a transparent latch, or through an edge-triggered flip-flop. A fixed-level mode ignores all routing and drives a constant, which stands in for a jumper or DIP switch. A single wide write loads the configuration word. Until that first write the pad stays at high impedance.

A two-state configuration machine tracks whether the cell holds a valid setup. The states are `CFG_EMPTY`, entered on reset, and `CFG_LOADED`. The transition `CFG_EMPTY -> CFG_LOADED` happens on a write. The transition `CFG_LOADED -> CFG_LOADED` happens on any later write, which replaces the word. Only reset leads back to `CFG_EMPTY`.

Top module: `xpt_out_cell`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cfg_done` and `pad_drive` are 0 and the storage latch and flip-flop hold 0. Reset acts asynchronously.
- R2: The pad is not driven before a write. A rising `clk` with `cfg_we` high loads the whole `cfg_wdata` word, and `cfg_done` reads 1 from the next cycle on. A later write replaces the entire word.
- R3: The configuration word has these fields. Bits [1:0] hold the data mode. Bits [3:2] hold the fixed-level mode. Bits [7:4] hold the invert flags for oe, clk, sel0 and sel1. Starting at bit 8 come four 3-bit data indices, for groups A, B, C and D in that order. Starting at bit 20 come four 5-bit pool indices, for oe, clk, sel0 and sel1 in that order. Data candidate k is bit `index_k` of group k. With {sel1,sel0} at 0, 1, 2 or 3, the cell picks A, B, C or D respectively.
- R4: A control pool index i selects bit i of `{grp_d, grp_c, grp_b, grp_a}`. Indices 0 to 7 therefore address group A, and indices 24 to 31 address group D.
- R5: When an invert flag is 1, the matching control line is active at the opposite level of its pin.
- R6: With fixed-level mode off, `pad_drive` equals the effective output enable. When `pad_drive` is 0, `pad_out` is 'z'.
- R7: In data mode 00, and in the spare code 11, `pad_out` follows the selected candidate with no clock.
- R8: In data mode 01, the latch passes data while the effective clock is 1 and holds its value while that clock is 0.
- R9: In data mode 10, the flip-flop loads only on a rising edge of the effective clock and holds otherwise.
- R10: Fixed-level code 11 drives 1 and code 10 drives 0, both with `pad_drive` at 1, whatever the enable and data inputs do. Code 00 and the spare code 01 leave the routing in charge.
- R11: A single pin may act as a data source and a control source at the same time, with no restriction on fanout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W (40) | Configuration word |
| grp_a | input | GROUP_W (8) | Input pin group A |
| grp_b | input | GROUP_W (8) | Input pin group B |
| grp_c | input | GROUP_W (8) | Input pin group C |
| grp_d | input | GROUP_W (8) | Input pin group D |
| cfg_done | output | 1 | Cell holds a valid configuration |
| pad_drive | output | 1 | Pad is actively driven |
| pad_out | output | 1 | Pad value, 'z' when not driven |

## Verification
The bench first holds the pins active while the cell is unconfigured. A cell that enabled its driver from stale or reset fields would drive the pad here. It then drives a value into the latch, closes the latch, and changes the data while the latch is closed. A latch built as a plain wire, or one with its enable inverted, would show the new data at the pad. In registered mode it changes the data while the clock is flat, which catches a flip-flop that samples levels rather than edges, and it checks that an asynchronous reset clears a stored 1. Fixed-level codes are applied with the enable inactive, so an override that still obeys the enable leaves the pad floating. The polarity and pool-index tests catch controls that are swapped or read from the wrong group.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic [1:0] {
        DM_COMB  = 2'b00,
        DM_LATCH = 2'b01,
        DM_REG   = 2'b10,
        DM_SPARE = 2'b11
    } data_mode_e;

    typedef enum logic [1:0] {
        FX_OFF   = 2'b00,
        FX_SPARE = 2'b01,
        FX_LOW   = 2'b10,
        FX_HIGH  = 2'b11
    } fix_mode_e;

    typedef enum logic {
        CFG_EMPTY  = 1'b0,
        CFG_LOADED = 1'b1
    } cfg_state_e;

    // control line positions inside the invert and source fields
    localparam int CTL_OE   = 0;
    localparam int CTL_CLK  = 1;
    localparam int CTL_SEL0 = 2;
    localparam int CTL_SEL1 = 3;
    localparam int N_CTL    = 4;
    localparam int N_GROUPS = 4;

endpackage

// File: rtl/xpt_cfg_store.sv
module xpt_cfg_store
    import xpt_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int CTRL_W = 5,
    localparam int DSRC_LSB = 8,
    localparam int CSRC_LSB = DSRC_LSB + N_GROUPS * SEL_W,
    localparam int CFG_W    = CSRC_LSB + N_CTL * CTRL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CFG_W-1:0]           cfg_wdata,
    output data_mode_e                 mode,
    output fix_mode_e                  fix,
    output logic [N_CTL-1:0]           inv,
    output logic [N_GROUPS*SEL_W-1:0]  dsrc,
    output logic [N_CTL*CTRL_W-1:0]    csrc,
    output logic                       cfg_done
);

    cfg_state_e       state_q, state_d;
    logic [CFG_W-1:0] word_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_EMPTY;
        else        state_q <= state_d;
    end

    // configuration word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (cfg_we) word_q <= cfg_wdata;
    end

    // transitions and outputs
    always_comb begin
        state_d  = state_q;
        cfg_done = 1'b0;
        unique case (state_q)
            CFG_EMPTY: begin
                if (cfg_we) state_d = CFG_LOADED;
            end
            CFG_LOADED: begin
                cfg_done = 1'b1;
            end
            default: state_d = CFG_EMPTY;
        endcase
    end

    assign mode = data_mode_e'(word_q[1:0]);
    assign fix  = fix_mode_e'(word_q[3:2]);
    assign inv  = word_q[7:4];
    assign dsrc = word_q[DSRC_LSB +: N_GROUPS*SEL_W];
    assign csrc = word_q[CSRC_LSB +: N_CTL*CTRL_W];

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_done);

    assert_cfg_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

endmodule

// File: rtl/xpt_route_pool.sv
module xpt_route_pool
    import xpt_pkg::*;
#(
    parameter int GROUP_W = 8,
    parameter int SEL_W   = 3,
    parameter int CTRL_W  = 5
) (
    input  logic [GROUP_W-1:0]          grp_a,
    input  logic [GROUP_W-1:0]          grp_b,
    input  logic [GROUP_W-1:0]          grp_c,
    input  logic [GROUP_W-1:0]          grp_d,
    input  logic [N_GROUPS*SEL_W-1:0]   dsrc,
    input  logic [N_CTL*CTRL_W-1:0]     csrc,
    input  logic [N_CTL-1:0]            inv,
    output logic [N_GROUPS-1:0]         data,
    output logic [N_CTL-1:0]            ctl
);

    logic [GROUP_W-1:0]          grp [N_GROUPS];
    logic [N_GROUPS*GROUP_W-1:0] pool;

    assign grp[0] = grp_a;
    assign grp[1] = grp_b;
    assign grp[2] = grp_c;
    assign grp[3] = grp_d;
    assign pool   = {grp_d, grp_c, grp_b, grp_a};

    // each group feeds exactly one data candidate
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_data
        assign data[g] = grp[g][dsrc[g*SEL_W +: SEL_W]];
    end

    // each control line draws from the whole pool, then polarity is applied
    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
        assign ctl[c] = pool[csrc[c*CTRL_W +: CTRL_W]] ^ inv[c];
    end

endmodule

// File: rtl/xpt_store_path.sv
module xpt_store_path
    import xpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  data_mode_e          mode,
    input  logic [N_GROUPS-1:0] data,
    input  logic [1:0]          sel,
    input  logic                eclk,
    output logic                q
);

    logic mux_q;
    logic lat_q;
    logic ff_q;

    assign mux_q = data[sel];

    always_latch begin
        if (!rst_n)    lat_q = 1'b0;
        else if (eclk) lat_q = mux_q;
    end

    always_ff @(posedge eclk or negedge rst_n) begin
        if (!rst_n) ff_q <= 1'b0;
        else        ff_q <= mux_q;
    end

    always_comb begin
        unique case (mode)
            DM_LATCH: q = lat_q;
            DM_REG:   q = ff_q;
            default:  q = mux_q;
        endcase
    end

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eclk && $past(!eclk)) |-> $stable(lat_q));

    assert_ff_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(eclk) |-> $stable(ff_q));

endmodule

// File: rtl/xpt_out_cell.sv
module xpt_out_cell
    import xpt_pkg::*;
#(
    parameter int GROUP_W = 8,
    localparam int SEL_W  = $clog2(GROUP_W),
    localparam int CTRL_W = $clog2(N_GROUPS * GROUP_W),
    localparam int CFG_W  = 8 + N_GROUPS * SEL_W + N_CTL * CTRL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [GROUP_W-1:0] grp_a,
    input  logic [GROUP_W-1:0] grp_b,
    input  logic [GROUP_W-1:0] grp_c,
    input  logic [GROUP_W-1:0] grp_d,
    output logic               cfg_done,
    output logic               pad_drive,
    output logic               pad_out
);

    data_mode_e                 mode;
    fix_mode_e                  fix;
    logic [N_CTL-1:0]           inv;
    logic [N_GROUPS*SEL_W-1:0]  dsrc;
    logic [N_CTL*CTRL_W-1:0]    csrc;
    logic [N_GROUPS-1:0]        data;
    logic [N_CTL-1:0]           ctl;
    logic                       store_q;
    logic                       level;
    logic                       fixed_on;

    xpt_cfg_store #(.SEL_W(SEL_W), .CTRL_W(CTRL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode(mode), .fix(fix), .inv(inv), .dsrc(dsrc), .csrc(csrc),
        .cfg_done(cfg_done)
    );

    xpt_route_pool #(.GROUP_W(GROUP_W), .SEL_W(SEL_W), .CTRL_W(CTRL_W)) u_route (
        .grp_a(grp_a), .grp_b(grp_b), .grp_c(grp_c), .grp_d(grp_d),
        .dsrc(dsrc), .csrc(csrc), .inv(inv), .data(data), .ctl(ctl)
    );

    xpt_store_path u_store (
        .clk(clk), .rst_n(rst_n), .mode(mode), .data(data),
        .sel({ctl[CTL_SEL1], ctl[CTL_SEL0]}), .eclk(ctl[CTL_CLK]), .q(store_q)
    );

    assign fixed_on = (fix == FX_HIGH) || (fix == FX_LOW);

    always_comb begin
        unique case (fix)
            FX_HIGH: level = 1'b1;
            FX_LOW:  level = 1'b0;
            default: level = store_q;
        endcase
    end

    assign pad_drive = cfg_done && (fixed_on || ctl[CTL_OE]);
    assign pad_out   = pad_drive ? level : 1'bz;

    assert_hiz_unconfigured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !pad_drive);

    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !fixed_on && !ctl[CTL_OE]) |-> !pad_drive);

    assert_fix_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && fix == FX_HIGH) |-> (pad_drive && pad_out));

    assert_fix_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && fix == FX_LOW) |-> (pad_drive && !pad_out));

endmodule

// File: tb/xpt_out_cell_bench.sv
module xpt_out_cell_bench;

    localparam int PERIOD  = 10;
    localparam int GROUP_W = 8;
    localparam int CFG_W   = 40;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [CFG_W-1:0]   cfg_wdata = '0;
    logic [GROUP_W-1:0] grp_a = '0, grp_b = '0, grp_c = '0, grp_d = '0;
    logic               cfg_done, pad_drive, pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    xpt_out_cell #(.GROUP_W(GROUP_W)) u_xpt_out_cell (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .grp_a(grp_a), .grp_b(grp_b), .grp_c(grp_c), .grp_d(grp_d),
        .cfg_done(cfg_done), .pad_drive(pad_drive), .pad_out(pad_out)
    );

    // word layout per R3
    function automatic logic [CFG_W-1:0] mk_cfg(
        input logic [1:0] dm, input logic [1:0] fx, input logic [3:0] iv,
        input logic [2:0] da, input logic [2:0] db, input logic [2:0] dc, input logic [2:0] dd,
        input logic [4:0] coe, input logic [4:0] cclk, input logic [4:0] cs0, input logic [4:0] cs1);
        return {cs1, cs0, cclk, coe, dd, dc, db, da, iv, fx, dm};
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // pad check: drive flag always, value only when driven
    task automatic check_pad(input string req, input logic exp_drv, input logic exp_val);
        check(req, pad_drive, exp_drv);
        if (exp_drv) check(req, pad_out, exp_val);
    endtask

    task automatic pins(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        grp_a = a; grp_b = b; grp_c = c; grp_d = d;
        #2;
    endtask

    task automatic load(input logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // stimulus {a, b, c, d, exp_drive, exp_value}; oe=a0, A=a1, sel0=a6, sel1=a7,
    // B=b2, C=c3, D=d4
    localparam logic [33:0] VEC [10] = '{
        {8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0},
        {8'h03, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},
        {8'h01, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0},
        {8'h41, 8'h04, 8'h00, 8'h00, 1'b1, 1'b1},
        {8'h43, 8'hFB, 8'h00, 8'h00, 1'b1, 1'b0},
        {8'h81, 8'h00, 8'h08, 8'h00, 1'b1, 1'b1},
        {8'h83, 8'hFF, 8'hF7, 8'hFF, 1'b1, 1'b0},
        {8'hC1, 8'h00, 8'h00, 8'h10, 1'b1, 1'b1},
        {8'hC3, 8'hFF, 8'hFF, 8'hEF, 1'b1, 1'b0},
        {8'hC2, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}
    };

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 cfg_done in reset", cfg_done, 1'b0);
        check("R1 drive in reset", pad_drive, 1'b0);
        rst_n = 1'b1;
        // R2 no drive while unconfigured, pins fully active
        pins(8'hFF, 8'hFF, 8'hFF, 8'hFF);
        check("R2 unconfigured drive", pad_drive, 1'b0);
        check("R1 cfg_done after release", cfg_done, 1'b0);

        // R3 R4 R6 R7 table walk in combinational mode
        load(mk_cfg(2'b00, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        check("R2 cfg_done after write", cfg_done, 1'b1);
        for (int i = 0; i < 10; i++) begin
            pins(VEC[i][33:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:2]);
            check_pad($sformatf("R3 R6 R7 vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R7 spare data code behaves as combinational
        load(mk_cfg(2'b11, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h23, 8'h00, 8'h00, 8'h00);
        check_pad("R7 spare mode high", 1'b1, 1'b1);
        pins(8'h21, 8'h00, 8'h00, 8'h00);
        check_pad("R7 spare mode low", 1'b1, 1'b0);

        // R5 invert oe and sel0
        load(mk_cfg(2'b00, 2'b00, 4'b0101, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h00, 8'h04, 8'h00, 8'h00);
        check_pad("R5 inverted oe and sel0 pick B", 1'b1, 1'b1);
        pins(8'h02, 8'h00, 8'h00, 8'h00);
        check_pad("R5 inverted sel0 ignores A", 1'b1, 1'b0);
        pins(8'h01, 8'h04, 8'h00, 8'h00);
        check_pad("R5 inverted oe disables", 1'b0, 1'b0);

        // R4 R11 controls from other groups, shared pin for oe and data
        load(mk_cfg(2'b00, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd1, 5'd5, 5'd31, 5'd7));
        pins(8'h02, 8'h00, 8'h00, 8'h00);
        check_pad("R11 shared pin drives oe and data", 1'b1, 1'b1);
        pins(8'h00, 8'h04, 8'h00, 8'h00);
        check_pad("R11 shared pin low disables", 1'b0, 1'b0);
        pins(8'h02, 8'h04, 8'h00, 8'h80);
        check_pad("R4 sel0 from group D bit 7", 1'b1, 1'b1);
        pins(8'h02, 8'h00, 8'h00, 8'h80);
        check_pad("R4 sel0 from group D picks B low", 1'b1, 1'b0);
        load(mk_cfg(2'b00, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd19, 5'd5, 5'd6, 5'd7));
        pins(8'h02, 8'h00, 8'h08, 8'h00);
        check_pad("R4 oe from group C bit 3", 1'b1, 1'b1);
        pins(8'h02, 8'h00, 8'h00, 8'h00);
        check_pad("R4 oe from group C low", 1'b0, 1'b0);

        // R10 fixed levels with oe inactive and data moving
        load(mk_cfg(2'b00, 2'b11, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h00, 8'h00, 8'h00, 8'h00);
        check_pad("R10 fixed high", 1'b1, 1'b1);
        load(mk_cfg(2'b00, 2'b10, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h02, 8'h00, 8'h00, 8'h00);
        check_pad("R10 fixed low", 1'b1, 1'b0);
        load(mk_cfg(2'b00, 2'b01, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h02, 8'h00, 8'h00, 8'h00);
        check_pad("R10 spare fixed code follows routing", 1'b0, 1'b0);

        // R8 latch, clock on a5
        load(mk_cfg(2'b01, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h23, 8'h00, 8'h00, 8'h00);
        check_pad("R8 transparent high", 1'b1, 1'b1);
        pins(8'h21, 8'h00, 8'h00, 8'h00);
        check_pad("R8 transparent low", 1'b1, 1'b0);
        pins(8'h23, 8'h00, 8'h00, 8'h00);
        pins(8'h03, 8'h00, 8'h00, 8'h00);
        pins(8'h01, 8'h00, 8'h00, 8'h00);
        check_pad("R8 hold while clock low", 1'b1, 1'b1);
        pins(8'h21, 8'h00, 8'h00, 8'h00);
        check_pad("R8 reopen", 1'b1, 1'b0);
        // R5 R8 inverted latch clock
        load(mk_cfg(2'b01, 2'b00, 4'b0010, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h03, 8'h00, 8'h00, 8'h00);
        check_pad("R5 inverted latch clock open", 1'b1, 1'b1);
        pins(8'h01, 8'h00, 8'h00, 8'h00);
        pins(8'h21, 8'h00, 8'h00, 8'h00);
        pins(8'h23, 8'h00, 8'h00, 8'h00);
        check_pad("R5 inverted latch clock holds", 1'b1, 1'b0);

        // R9 flip-flop, clock on a5
        load(mk_cfg(2'b10, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h01, 8'h00, 8'h00, 8'h00);
        pins(8'h21, 8'h00, 8'h00, 8'h00);
        check_pad("R9 capture 0", 1'b1, 1'b0);
        pins(8'h01, 8'h00, 8'h00, 8'h00);
        pins(8'h03, 8'h00, 8'h00, 8'h00);
        check_pad("R9 no capture without edge", 1'b1, 1'b0);
        pins(8'h23, 8'h00, 8'h00, 8'h00);
        check_pad("R9 capture on rising edge", 1'b1, 1'b1);
        pins(8'h21, 8'h00, 8'h00, 8'h00);
        check_pad("R9 hold while clock high", 1'b1, 1'b1);
        pins(8'h01, 8'h00, 8'h00, 8'h00);
        check_pad("R9 hold on falling edge", 1'b1, 1'b1);

        // R1 R9 asynchronous reset clears the stored 1 and the configuration
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        check("R1 drive during reset", pad_drive, 1'b0);
        check("R1 cfg_done during reset", cfg_done, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R2 unconfigured after reset", pad_drive, 1'b0);
        load(mk_cfg(2'b10, 2'b00, 4'h0, 3'd1, 3'd2, 3'd3, 3'd4, 5'd0, 5'd5, 5'd6, 5'd7));
        pins(8'h03, 8'h00, 8'h00, 8'h00);
        check_pad("R9 flop cleared by reset", 1'b1, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule